// File: doc/BRIEF.md
# Single-Lane Packet Receive Sender

This block moves packets from one port's receive FIFO onto a dedicated 8-bit receive bus toward a network processor. Each port has its own copy of the block, with its own lane and control lines. No port address cycles are sent, and no byte-count modifier is needed. Every data cycle carries exactly one byte, and the end-of-packet cycle is no exception.

The FIFO side is a show-ahead read interface. The head byte and its start, end and error markers are visible whenever the FIFO is not empty, and a one-cycle read strobe pops that entry. On the bus side the block drives registered data, a valid flag, start and end markers, an error flag and parity. It stops whenever the processor lowers its read enable.

Traffic is cut into bursts of a programmable length. An optional fixed pause of two idle cycles follows every burst. Parity sense can be selected, and the reset setting is odd.

Top module: `sphy_rx_sender`

## Requirements
- R1: While reset is asserted, bus_val, bus_sop, bus_eop and bus_err are 0 and bus_data is 0x00.
- R2: When proc_ren is 1, the FIFO is not empty and no pause is running, fifo_rd is 1. In the following cycle bus_val is 1 and bus_data equals the byte that was at the FIFO head.
- R3: While proc_ren is 0, fifo_rd is 0. One cycle later bus_val is 0, and bus_data, bus_sop, bus_eop and bus_err keep their previous values. When proc_ren returns to 1, output resumes with the next unread byte.
- R4: bus_sop and bus_eop copy the FIFO start and end markers of the byte being sent. bus_err is 1 only in a cycle where bus_eop is 1, and only when the FIFO error marker is set on that end byte.
- R5: With cfg_pause_two = 1, exactly two cycles with bus_val = 0 follow every burst. A burst ends after max(cfg_burst_len,1) bytes or at a packet's last byte, whichever comes first.
- R6: With cfg_pause_two = 0 and proc_ren held at 1, a FIFO that is not empty streams one byte per cycle, with no gaps across bursts or packets.
- R7: The end of a packet clears the burst count. The next packet starts a full-length burst, and a packet ending exactly on a burst boundary gets only one pause.
- R8: bus_par is set so that the 9 bits {bus_data, bus_par} hold an odd number of ones when cfg_even_par = 0, and an even number when cfg_even_par = 1. This holds in idle cycles too.
- R9: When proc_ren is 1 but no byte is read, the next cycle shows bus_val, bus_sop, bus_eop and bus_err at 0 and bus_data at 0x00.
- R10: cfg_burst_len = 0 behaves as a burst length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | BURST_W | Bytes per burst (0 acts as 1) |
| cfg_pause_two | input | 1 | 1 inserts two idle cycles after each burst |
| cfg_even_par | input | 1 | 0 selects odd parity, 1 selects even parity |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_sop | input | 1 | Head byte starts a packet |
| fifo_eop | input | 1 | Head byte ends a packet |
| fifo_err | input | 1 | Packet error marker of the head byte |
| fifo_rd | output | 1 | Pops the FIFO head at the clock edge |
| proc_ren | input | 1 | Processor read enable |
| bus_data | output | 8 | Bus data byte |
| bus_val | output | 1 | Bus data is valid this cycle |
| bus_sop | output | 1 | Start of packet |
| bus_eop | output | 1 | End of packet |
| bus_err | output | 1 | Errored packet, valid with bus_eop |
| bus_par | output | 1 | Parity over bus_data |

## Verification
The burst and pause counters have no port of their own. A corrupted count shows up directly in the pattern of gaps. A wrong burst count moves the two-cycle hole by one or more bytes. A pause counter that is stuck at zero or never clears either removes the hole or stalls the stream. In each case the error is visible at bus_val within one burst length of the fault. A wrong output register shows up in the very next cycle as a byte, marker or parity mismatch, because every bus output is registered exactly once after the FIFO read.

// File: rtl/sphy_rx_sender.sv
module sphy_rx_sender #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic               cfg_pause_two,
  input  logic               cfg_even_par,
  input  logic               fifo_empty,
  input  logic [7:0]         fifo_data,
  input  logic               fifo_sop,
  input  logic               fifo_eop,
  input  logic               fifo_err,
  output logic               fifo_rd,
  input  logic               proc_ren,
  output logic [7:0]         bus_data,
  output logic               bus_val,
  output logic               bus_sop,
  output logic               bus_eop,
  output logic               bus_err,
  output logic               bus_par
);
  localparam logic [1:0] PAUSE_CYC = 2'd2;
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  logic [BURST_W-1:0] burst_cnt, burst_lim;
  logic [1:0]         pause_cnt;
  logic               burst_done;

  assign burst_lim  = (cfg_burst_len == '0) ? ONE : cfg_burst_len;
  assign burst_done = fifo_eop || (burst_cnt + ONE == burst_lim);
  assign fifo_rd    = proc_ren && !fifo_empty && (pause_cnt == 2'd0);
  assign bus_par    = cfg_even_par ? ^bus_data : ~^bus_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_cnt <= '0;
      pause_cnt <= 2'd0;
      bus_data  <= 8'h00;
      bus_val   <= 1'b0;
      bus_sop   <= 1'b0;
      bus_eop   <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      if (pause_cnt != 2'd0) pause_cnt <= pause_cnt - 2'd1;
      if (!proc_ren) begin
        bus_val <= 1'b0;
      end else if (fifo_rd) begin
        bus_data <= fifo_data;
        bus_val  <= 1'b1;
        bus_sop  <= fifo_sop;
        bus_eop  <= fifo_eop;
        bus_err  <= fifo_eop && fifo_err;
        if (burst_done) begin
          burst_cnt <= '0;
          pause_cnt <= cfg_pause_two ? PAUSE_CYC : 2'd0;
        end else begin
          burst_cnt <= burst_cnt + ONE;
        end
      end else begin
        bus_data <= 8'h00;
        bus_val  <= 1'b0;
        bus_sop  <= 1'b0;
        bus_eop  <= 1'b0;
        bus_err  <= 1'b0;
      end
    end
  end

  assert_read_shows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> bus_val && bus_data == $past(fifo_data));

  assert_ren_low_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_ren |=> !bus_val && $stable(bus_data) && $stable(bus_eop));

  assert_err_with_eop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_eop);

  assert_pause_after_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_val && bus_eop && cfg_pause_two |=> !bus_val ##1 !bus_val);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_ren && !fifo_rd |=> !bus_val && bus_data == 8'h00 && !bus_sop);
endmodule

// File: tb/tb_sphy_rx_sender.sv
`timescale 1ns/1ps
module tb_sphy_rx_sender;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cfg_pause_two = 1'b0, cfg_even_par = 1'b0, proc_ren = 1'b0;
  logic [7:0] cfg_burst_len = 8'd4;
  logic fifo_empty, fifo_sop, fifo_eop, fifo_err, fifo_rd;
  logic [7:0] fifo_data, bus_data;
  logic bus_val, bus_sop, bus_eop, bus_err, bus_par;

  logic [7:0] mem_d [64];
  logic mem_s [64], mem_e [64], mem_r [64];
  int wr_ptr = 0, rd_ptr = 0;
  int checks = 0, errors = 0;

  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = mem_d[rd_ptr[5:0]];
  assign fifo_sop   = mem_s[rd_ptr[5:0]];
  assign fifo_eop   = mem_e[rd_ptr[5:0]];
  assign fifo_err   = mem_r[rd_ptr[5:0]];
  always @(posedge clk) if (!rst_n) rd_ptr <= 0; else if (fifo_rd) rd_ptr <= rd_ptr + 1;

  sphy_rx_sender #(.BURST_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_burst_len), .cfg_pause_two(cfg_pause_two),
    .cfg_even_par(cfg_even_par), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_sop(fifo_sop), .fifo_eop(fifo_eop), .fifo_err(fifo_err), .fifo_rd(fifo_rd),
    .proc_ren(proc_ren), .bus_data(bus_data), .bus_val(bus_val), .bus_sop(bus_sop),
    .bus_eop(bus_eop), .bus_err(bus_err), .bus_par(bus_par));

  typedef struct packed {
    logic [7:0] len; logic pause; logic even; logic [3:0] na; logic [3:0] nb; logic err;
  } vec_t;

  // R7: vectors 3 and 4 cover partial and boundary bursts; R10: vector 2 uses length 0
  localparam vec_t VEC [5] = '{
    '{8'd4, 1'b1, 1'b0, 4'd6, 4'd3, 1'b1},
    '{8'd4, 1'b0, 1'b1, 4'd5, 4'd2, 1'b0},
    '{8'd0, 1'b1, 1'b0, 4'd2, 4'd1, 1'b0},
    '{8'd8, 1'b1, 1'b1, 4'd3, 4'd5, 1'b1},
    '{8'd3, 1'b1, 1'b0, 4'd3, 4'd3, 1'b0}};

  logic [7:0] ex_d [64];
  logic ex_v [64], ex_s [64], ex_e [64], ex_r [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic s, input logic e, input logic r);
    mem_d[wr_ptr[5:0]] = d; mem_s[wr_ptr[5:0]] = s;
    mem_e[wr_ptr[5:0]] = e; mem_r[wr_ptr[5:0]] = r;
    wr_ptr++;
  endtask

  function automatic logic [7:0] pbyte(input int p, input int i);
    return 8'(i * 37 + p * 91 + 5);
  endfunction

  task automatic do_reset();
    proc_ren = 1'b0; rst_n = 1'b0; wr_ptr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!bus_val && !bus_sop && !bus_eop && !bus_err && bus_data == 8'h00, "R1",
        {bus_val, bus_sop, bus_eop, bus_err, bus_data}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired (all) actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int v = 0; v < 5; v++) begin
      automatic vec_t t = VEC[v];
      automatic int lim = (t.len == 0) ? 1 : int'(t.len);
      automatic int k = 0, cnt = 0;
      automatic string vreq = (v == 2) ? "R10" : (v >= 3) ? "R7" : t.pause ? "R5" : "R6";
      cfg_burst_len = t.len; cfg_pause_two = t.pause; cfg_even_par = t.even;
      do_reset();
      for (int j = 0; j < 64; j++) begin
        ex_v[j] = 0; ex_d[j] = 0; ex_s[j] = 0; ex_e[j] = 0; ex_r[j] = 0;
      end
      for (int p = 0; p < 2; p++) begin
        automatic int n = p ? int'(t.nb) : int'(t.na);
        for (int i = 0; i < n; i++) begin
          push(pbyte(p, i), i == 0, i == n - 1, p == 1 && t.err);
          ex_v[k] = 1; ex_d[k] = pbyte(p, i); ex_s[k] = (i == 0);
          ex_e[k] = (i == n - 1); ex_r[k] = (p == 1 && t.err && i == n - 1);
          k++; cnt++;
          if (i == n - 1 || cnt == lim) begin
            cnt = 0;
            if (t.pause) k += 2;
          end
        end
      end
      @(negedge clk);
      proc_ren = 1'b1;
      for (int c = 0; c < 48; c++) begin
        @(posedge clk); @(negedge clk);
        chk(bus_val == ex_v[c], vreq, bus_val, ex_v[c]);
        if (ex_v[c]) begin
          chk(bus_data == ex_d[c], "R2", bus_data, ex_d[c]);
          chk({bus_sop, bus_eop, bus_err} == {ex_s[c], ex_e[c], ex_r[c]}, "R4",
              {bus_sop, bus_eop, bus_err}, {ex_s[c], ex_e[c], ex_r[c]});
        end else begin
          chk(bus_data == 8'h00 && !bus_sop && !bus_eop && !bus_err, "R9",
              {bus_sop, bus_eop, bus_err, bus_data}, 0);
        end
        chk((^{bus_data, bus_par}) == !t.even, "R8", bus_par, bus_par ^ 1'b1);
      end
    end

    // R3: read enable low holds outputs and consumes nothing
    cfg_burst_len = 8'd8; cfg_pause_two = 1'b0; cfg_even_par = 1'b1;
    do_reset();
    for (int i = 0; i < 4; i++) push(pbyte(2, i), i == 0, i == 3, 1'b0);
    @(negedge clk); proc_ren = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(bus_val && bus_data == pbyte(2, 0) && bus_sop, "R2", bus_data, pbyte(2, 0));
    @(posedge clk); @(negedge clk);
    proc_ren = 1'b0;
    #0.1;
    chk(!fifo_rd, "R3", fifo_rd, 0);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk(!bus_val && bus_data == pbyte(2, 1) && rd_ptr == 2, "R3", bus_data, pbyte(2, 1));
    end
    proc_ren = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(bus_val && bus_data == pbyte(2, 2), "R3", bus_data, pbyte(2, 2));
    @(posedge clk); @(negedge clk);
    chk(bus_val && bus_eop && bus_data == pbyte(2, 3), "R4", bus_data, pbyte(2, 3));
    repeat (3) begin @(posedge clk); @(negedge clk); end
    // R9 with even parity on an empty FIFO: zero data, parity 0
    chk(!bus_val && bus_data == 8'h00 && !bus_eop, "R9", bus_data, 0);
    chk(bus_par == 1'b0, "R8", bus_par, 0);
    cfg_even_par = 1'b0;
    #0.1;
    chk(bus_par == 1'b1, "R8", bus_par, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule